// File: doc/BRIEF.md
# Keyed-Restart Watchdog Timer

This block is a watchdog timer with a small 32-bit register interface. Software sets it up through one configuration word. That word holds three enable bits, an 8-bit expiry threshold, an 8-bit interrupt threshold and a 3-bit rate selector. An 8-bit up-counter advances at a rate derived from an external base tick of 256 Hz. The base tick arrives as single-cycle pulses on `base_tick`. An internal prescaler divides it down to the selected rate.

Software keeps the system alive by writing one fixed key byte to the restart word. Any other value written there is ignored. If the count reaches the expiry threshold first, the block raises a one-cycle reset request and stops counting. A second, lower threshold raises a level interrupt to warn software before expiry.

The register port has no flow control. A write is a single cycle with `bus_sel` and `bus_wr` both high. Read data follows `bus_addr` combinationally. The block never stalls the bus, so no back-pressure rules apply.

Top module: `keyed_wdt`

## Requirements
- R1: After reset, the configuration word (byte offset 0x0) reads 0x00FFFF00, the count reads 0, and `irq` and `rst_req` are low.
- R2: Configuration word field positions: bit 0 is the counter enable, bit 1 the interrupt enable and bit 2 the expiry enable. Bits 15:8 hold the expiry threshold, bits 23:16 the interrupt threshold and bits 26:24 the rate select. All other bits ignore writes and read 0. The count reads at offset 0xC in bits 7:0, with the upper bits 0. The restart word is at offset 0x4 and reads 0.
- R3: The count advances only while all of these hold: the counter enable is 1, the expiry enable is 1, and the rate select is one of 1 to 4. Rate select 0 and codes 5 to 7 hold the count.
- R4: Rate select 1, 2, 3 and 4 advance the count once every 2, 16, 256 and 4096 base-tick pulses respectively. The pulses are counted from the most recent valid restart.
- R5: A write to offset 0x4 whose bits 7:0 equal 0xB2 clears the count, the prescaler, the interrupt and the expired state. A write of any other value to offset 0x4 changes nothing.
- R6: On the count step that makes the count equal to the expiry threshold, `rst_req` goes high for exactly one cycle. Counting then stops and the count holds until a valid restart.
- R7: `irq` is a level output. It is set on the count step that makes the count equal to the interrupt threshold, but only while the interrupt enable is 1. It stays high until a valid restart.
- R8: Writing the configuration word does not clear the count. Clearing the counter enable freezes the count at its current value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| base_tick | input | 1 | Single-cycle base tick pulse (256 Hz) |
| bus_sel | input | 1 | Register access select |
| bus_wr | input | 1 | Write strobe; with `bus_sel`, writes in this cycle |
| bus_addr | input | ADDR_W | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| irq | output | 1 | Interrupt level |
| rst_req | output | 1 | One-cycle system reset request |

## Verification
The bench measures the exact number of cycles from a restart to the expiry pulse for all four rates. A prescaler tapped at the wrong bit, or one that keeps running across a restart, therefore shows up as an off-by-N cycle count.

It writes near-miss keys: a wrong low byte, and the right byte in the wrong lane. A design that compares the whole word, or any byte lane, either fails to restart or restarts by mistake.

It sets each gating condition on its own: rate code 0, an undefined rate code, and expiry disabled. A design that decodes only some of these keeps counting and diverges from the reference model.

After expiry it waits and checks that the count holds, that the pulse did not repeat, and that `irq` stayed set. A design that wraps or re-arms would show a second pulse or a moving count.

// File: rtl/kwd_pkg.sv
package kwd_pkg;
  localparam int CNT_W       = 8;
  localparam int OFF_CFG     = 'h0;
  localparam int OFF_RESTART = 'h4;
  localparam int OFF_COUNT   = 'hC;
  localparam logic [7:0] RESTART_KEY = 8'hB2;

  // rate select codes; 5..7 are undefined and stop the counter
  localparam logic [2:0] RATE_OFF  = 3'd0;
  localparam logic [2:0] RATE_128  = 3'd1;
  localparam logic [2:0] RATE_16   = 3'd2;
  localparam logic [2:0] RATE_1    = 3'd3;
  localparam logic [2:0] RATE_SLOW = 3'd4;

  typedef struct packed {
    logic [2:0]       rate;
    logic [CNT_W-1:0] irq_thr;
    logic [CNT_W-1:0] exp_thr;
    logic             exp_en;
    logic             irq_en;
    logic             cnt_en;
  } cfg_t;

  localparam cfg_t CFG_INIT = '{rate: RATE_OFF, irq_thr: '1, exp_thr: '1,
                                exp_en: 1'b0, irq_en: 1'b0, cnt_en: 1'b0};
endpackage

// File: rtl/kwd_regs.sv
module kwd_regs
  import kwd_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sel,
  input  logic              wr,
  input  logic [ADDR_W-1:0] addr,
  input  logic [31:0]       wdata,
  input  logic [CNT_W-1:0]  cnt,
  output cfg_t              cfg,
  output logic              restart_hit,
  output logic [31:0]       rdata
);
  logic wr_cfg, wr_restart;

  assign wr_cfg      = sel && wr && (addr == ADDR_W'(OFF_CFG));
  assign wr_restart  = sel && wr && (addr == ADDR_W'(OFF_RESTART));
  assign restart_hit = wr_restart && (wdata[7:0] == RESTART_KEY);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cfg <= CFG_INIT;
    end else if (wr_cfg) begin
      cfg.cnt_en  <= wdata[0];
      cfg.irq_en  <= wdata[1];
      cfg.exp_en  <= wdata[2];
      cfg.exp_thr <= wdata[15:8];
      cfg.irq_thr <= wdata[23:16];
      cfg.rate    <= wdata[26:24];
    end
  end

  always_comb begin
    rdata = '0;
    if (addr == ADDR_W'(OFF_CFG)) begin
      rdata = {5'b0, cfg.rate, cfg.irq_thr, cfg.exp_thr,
               5'b0, cfg.exp_en, cfg.irq_en, cfg.cnt_en};
    end else if (addr == ADDR_W'(OFF_COUNT)) begin
      rdata = {{(32-CNT_W){1'b0}}, cnt};
    end
  end
endmodule

// File: rtl/kwd_prescaler.sv
module kwd_prescaler
  import kwd_pkg::*;
#(
  parameter int SH_128  = 1,
  parameter int SH_16   = 4,
  parameter int SH_1    = 8,
  parameter int SH_SLOW = 12
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       base_tick,
  input  logic       run,
  input  logic       clear,
  input  logic [2:0] rate,
  output logic       rate_valid,
  output logic       rate_tick
);
  localparam int PRE_W = SH_SLOW;
  localparam logic [PRE_W-1:0] ONES = {PRE_W{1'b1}};

  logic [PRE_W-1:0] pre_q;
  logic [PRE_W-1:0] mask;

  always_comb begin
    rate_valid = 1'b1;
    mask       = '0;
    case (rate)
      RATE_128:  mask = ONES >> (PRE_W - SH_128);
      RATE_16:   mask = ONES >> (PRE_W - SH_16);
      RATE_1:    mask = ONES >> (PRE_W - SH_1);
      RATE_SLOW: mask = ONES;
      default:   rate_valid = 1'b0;
    endcase
  end

  assign rate_tick = run && base_tick && ((pre_q & mask) == mask);

  always_ff @(posedge clk) begin
    if (!rst_n || clear || !run) begin
      pre_q <= '0;
    end else if (base_tick) begin
      pre_q <= pre_q + 1'b1;
    end
  end
endmodule

// File: rtl/kwd_core.sv
module kwd_core
  import kwd_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rate_tick,
  input  logic             clear,
  input  cfg_t             cfg,
  output logic [CNT_W-1:0] cnt,
  output logic             expired,
  output logic             irq,
  output logic             rst_req
);
  logic [CNT_W-1:0] cnt_nxt;

  assign cnt_nxt = cnt + 1'b1;

  always_ff @(posedge clk) begin
    if (!rst_n || clear) begin
      cnt     <= '0;
      expired <= 1'b0;
      irq     <= 1'b0;
      rst_req <= 1'b0;
    end else begin
      rst_req <= 1'b0;
      if (rate_tick) begin
        cnt <= cnt_nxt;
        if (cnt_nxt == cfg.exp_thr && cfg.exp_en) begin
          expired <= 1'b1;
          rst_req <= 1'b1;
        end
        if (cnt_nxt == cfg.irq_thr && cfg.irq_en) begin
          irq <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/keyed_wdt.sv
module keyed_wdt
  import kwd_pkg::*;
#(
  parameter int ADDR_W  = 8,
  parameter int SH_128  = 1,
  parameter int SH_16   = 4,
  parameter int SH_1    = 8,
  parameter int SH_SLOW = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              base_tick,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              irq,
  output logic              rst_req
);
  cfg_t             cfg;
  logic             restart_hit;
  logic             rate_valid;
  logic             rate_tick;
  logic             expired;
  logic             run;
  logic [CNT_W-1:0] cnt_q;

  assign run = cfg.cnt_en && cfg.exp_en && rate_valid && !expired;

  kwd_regs #(.ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .sel(bus_sel), .wr(bus_wr), .addr(bus_addr),
    .wdata(bus_wdata), .cnt(cnt_q), .cfg(cfg), .restart_hit(restart_hit),
    .rdata(bus_rdata)
  );

  kwd_prescaler #(.SH_128(SH_128), .SH_16(SH_16), .SH_1(SH_1), .SH_SLOW(SH_SLOW)) u_pre (
    .clk(clk), .rst_n(rst_n), .base_tick(base_tick), .run(run),
    .clear(restart_hit), .rate(cfg.rate), .rate_valid(rate_valid),
    .rate_tick(rate_tick)
  );

  kwd_core u_core (
    .clk(clk), .rst_n(rst_n), .rate_tick(rate_tick), .clear(restart_hit),
    .cfg(cfg), .cnt(cnt_q), .expired(expired), .irq(irq), .rst_req(rst_req)
  );
endmodule

// File: rtl/kwd_checker.sv
module kwd_checker
  import kwd_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             restart_hit,
  input logic             run,
  input logic [CNT_W-1:0] cnt,
  input logic             irq,
  input logic             rst_req
);
  assert_rst_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req |=> !rst_req);

  assert_hold_after_expiry_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (rst_req && !restart_hit) |=> $stable(cnt));

  assert_gated_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !restart_hit) |=> $stable(cnt));

  assert_step_by_one_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !restart_hit |=> (cnt == $past(cnt) || cnt == $past(cnt) + 8'd1));

  assert_key_clears_R5: assert property (@(posedge clk) disable iff (!rst_n)
    restart_hit |=> (cnt == '0 && !irq && !rst_req));

  assert_irq_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !restart_hit) |=> irq);
endmodule

bind keyed_wdt kwd_checker u_chk (
  .clk(clk), .rst_n(rst_n), .restart_hit(restart_hit), .run(run),
  .cnt(cnt_q), .irq(irq), .rst_req(rst_req)
);

// File: tb/keyed_wdt_tb_top.sv
module keyed_wdt_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        base_tick = 1'b0;
  logic        bus_sel = 1'b0;
  logic        bus_wr = 1'b0;
  logic [7:0]  bus_addr = 8'h0C;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        irq, rst_req;

  int total = 0;
  int bad = 0;
  int tick_period = 0;

  always #2.5 clk = ~clk;

  keyed_wdt dut_i (
    .clk(clk), .rst_n(rst_n), .base_tick(base_tick), .bus_sel(bus_sel),
    .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .irq(irq), .rst_req(rst_req)
  );

  // ---------------- reference model ----------------
  int m_en, m_ie, m_re, m_rv, m_iv, m_sel;
  int m_cnt, m_pre, m_exp, m_irq, m_rst;

  function automatic int divisor(int s);
    case (s)
      1: return 2;
      2: return 16;
      3: return 256;
      4: return 4096;
      default: return 0;
    endcase
  endfunction

  task automatic chk(bit ok, string tag, longint act, longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  always @(posedge clk) begin
    #1;
    if (!rst_n) begin
      m_en = 0; m_ie = 0; m_re = 0; m_rv = 255; m_iv = 255; m_sel = 0;
      m_cnt = 0; m_pre = 0; m_exp = 0; m_irq = 0; m_rst = 0;
    end else begin
      int div;
      bit go;
      div = divisor(m_sel);
      go  = (m_en != 0) && (m_re != 0) && (div != 0) && (m_exp == 0);
      if (bus_sel && bus_wr && bus_addr == 8'h04 && bus_wdata[7:0] == 8'hB2) begin
        m_cnt = 0; m_pre = 0; m_exp = 0; m_irq = 0; m_rst = 0;
      end else begin
        m_rst = 0;
        if (!go) m_pre = 0;
        else if (base_tick) begin
          if (m_pre % div == div - 1) begin
            m_cnt = (m_cnt + 1) % 256;
            if (m_cnt == m_rv) begin m_exp = 1; m_rst = 1; end
            if (m_ie != 0 && m_cnt == m_iv) m_irq = 1;
          end
          m_pre = (m_pre + 1) % 4096;
        end
      end
      if (bus_sel && bus_wr && bus_addr == 8'h00) begin
        m_en  = bus_wdata[0];
        m_ie  = bus_wdata[1];
        m_re  = bus_wdata[2];
        m_rv  = bus_wdata[15:8];
        m_iv  = bus_wdata[23:16];
        m_sel = bus_wdata[26:24];
      end
      chk(rst_req == m_rst[0], "R6 rst_req vs model", rst_req, m_rst);
      chk(irq == m_irq[0], "R7 irq vs model", irq, m_irq);
      if (bus_addr == 8'h0C)
        chk(bus_rdata == 32'(m_cnt), "R3/R4 count vs model", bus_rdata, m_cnt);
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic wait_cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr_reg(logic [7:0] a, logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0; bus_addr = 8'h0C; bus_wdata = '0;
  endtask

  task automatic rd_reg(logic [7:0] a, output logic [31:0] d);
    bus_addr = a;
    #0.5;
    d = bus_rdata;
    bus_addr = 8'h0C;
  endtask

  task automatic finish_up();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin : tick_gen
    int ph;
    ph = 0;
    forever begin
      @(negedge clk);
      if (tick_period == 0) base_tick = 1'b0;
      else begin
        ph = (ph + 1) % tick_period;
        base_tick = (ph == 0);
      end
    end
  end

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired actual=hung expected=done");
    finish_up();
  end

  // ---------------- main sequence ----------------
  initial begin : main
    logic [31:0] d, c1, c2;
    int n, pulses;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    rd_reg(8'h00, d); chk(d == 32'h00FFFF00, "R1 config reset", d, 32'h00FFFF00);
    rd_reg(8'h0C, d); chk(d == 0, "R1 count reset", d, 0);
    chk(!irq && !rst_req, "R1 outputs low", {irq, rst_req}, 0);

    // R2 field layout, reserved bits dropped
    wr_reg(8'h00, 32'hF10305F7);
    rd_reg(8'h00, d); chk(d == 32'h01030507, "R2 config readback", d, 32'h01030507);
    rd_reg(8'h04, d); chk(d == 0, "R2 restart reads zero", d, 0);

    // R6/R7 expiry at threshold 5, irq at 3, rate 128 (div 2), tick every 3 cycles
    wr_reg(8'h04, 32'hB2);
    tick_period = 3;
    pulses = 0;
    for (int i = 0; i < 200; i++) begin
      @(negedge clk);
      if (rst_req) pulses++;
    end
    chk(pulses == 1, "R6 single expiry pulse", pulses, 1);
    rd_reg(8'h0C, d); chk(d == 5, "R6 count holds at threshold", d, 5);
    chk(irq == 1'b1, "R7 irq raised and held", irq, 1);

    // R5 near-miss keys are ignored
    wr_reg(8'h04, 32'h000000B3);
    wr_reg(8'h04, 32'h0000B200);
    wait_cyc(4);
    rd_reg(8'h0C, d); chk(d == 5, "R5 wrong key ignored", d, 5);
    chk(irq == 1'b1, "R5 wrong key keeps irq", irq, 1);
    wr_reg(8'h04, 32'hFFFFFFB2);
    rd_reg(8'h0C, d); chk(d == 0, "R5 key clears count", d, 0);
    chk(irq == 1'b0, "R5 key clears irq", irq, 0);

    // R8 rewrite keeps count, disable freezes it
    wr_reg(8'h00, 32'h0103C807);
    wait_cyc(30);
    wr_reg(8'h00, 32'h0103C806);
    rd_reg(8'h0C, c1);
    chk(c1 != 0, "R8 rewrite keeps count", c1, 1);
    wait_cyc(40);
    rd_reg(8'h0C, c2); chk(c2 == c1, "R8 disable freezes count", c2, c1);

    // R3 gating: rate off, undefined rate, expiry disabled
    wr_reg(8'h00, 32'h0003C807);
    rd_reg(8'h0C, c1); wait_cyc(60); rd_reg(8'h0C, c2);
    chk(c2 == c1, "R3 rate off holds", c2, c1);
    wr_reg(8'h00, 32'h0503C807);
    rd_reg(8'h0C, c1); wait_cyc(60); rd_reg(8'h0C, c2);
    chk(c2 == c1, "R3 rate code 5 holds", c2, c1);
    wr_reg(8'h00, 32'h0703C807);
    rd_reg(8'h0C, c1); wait_cyc(60); rd_reg(8'h0C, c2);
    chk(c2 == c1, "R3 rate code 7 holds", c2, c1);
    wr_reg(8'h00, 32'h0103C803);
    rd_reg(8'h0C, c1); wait_cyc(60); rd_reg(8'h0C, c2);
    chk(c2 == c1, "R3 expiry disabled holds", c2, c1);

    // R4 exact restart-to-expiry latency per rate, tick every cycle
    tick_period = 1;
    for (int s = 1; s <= 4; s++) begin
      int expn;
      expn = divisor(s);
      wr_reg(8'h00, (s << 24) | 32'h00010105);
      wr_reg(8'h04, 32'hB2);
      n = 0;
      while (!rst_req && n < 5000) begin
        @(negedge clk);
        n++;
      end
      chk(n == expn, "R4 restart to expiry cycles", n, expn);
    end

    // R7 irq stays low with interrupt enable clear
    wr_reg(8'h00, 32'h01010305);
    wr_reg(8'h04, 32'hB2);
    wait_cyc(20);
    chk(irq == 1'b0, "R7 irq masked by enable", irq, 0);
    rd_reg(8'h0C, d); chk(d == 3, "R6 expired at threshold 3", d, 3);

    tick_period = 0;
    wait_cyc(5);
    finish_up();
  end
endmodule